// File: doc/BRIEF.md
# SPI Master Timing and Framing Engine

This block generates the serial clock and the chip-select framing for an SPI master. A single start pulse, qualified by a non-zero bit count, opens a frame: chip select goes active, a programmable setup interval passes, then the serial clock runs one cycle for each requested bit, a programmable hold interval follows, and chip select is released for a programmable idle gap before the engine reports completion. Each interval, and the high and low halves of the serial clock, is programmed on its own as a core-cycle count minus one. For example, a divide ratio `div` maps to half-periods of `(div+1)/2` cycles and to setup and hold times of twice that value.

Clock polarity and phase follow the usual CPOL/CPHA convention. A one-cycle sample strobe marks the core cycle that follows each serial-clock edge on which the receiver should capture data, so a shift register beside the engine needs no knowledge of the mode. A wide mode uses 16-bit timing counts and enables two extra options: an active-high chip select and sampling on the edge opposite the one CPHA selects. A compatible narrow mode keeps only the low 8 bits of each timing field, forces an active-low chip select, and ignores the alternate sample edge. All settings are captured when a start is accepted, so a host may reprogram them while a frame is in flight.

Top module: `spi_timing_gen`

## Requirements
- R1: While reset is held and on release, `cs_o` is 1 (inactive), `sck_o` is 0, and `busy_o`, `done_o` and `sample_o` are 0.
- R2: While idle, a cycle with `start_i`=1 and `nbits_i`≠0 opens a frame. Starting in the next cycle, `busy_o` is 1 and `cs_o` is at its active level for `cs_setup_i`+1 cycles before the first serial-clock edge.
- R3: `sck_o` rests at `cpol_i` outside the bit phases. For each of `nbits_i` bits it spends one phase at the level opposite `cpol_i` (the leading phase) and then one phase at `cpol_i`. Every stretch at level 1 lasts `sck_high_i`+1 cycles and every stretch at level 0 lasts `sck_low_i`+1 cycles.
- R4: After the trailing phase of the last bit, `cs_o` stays active for `cs_hold_i`+1 cycles and is then inactive for `cs_idle_i`+1 cycles (an 8-bit field) with `busy_o` still 1.
- R5: `done_o` is 1 for exactly one cycle: the first cycle after the idle gap, in which `busy_o` is already 0.
- R6: `sample_o` is 1 only in the first cycle of a phase. With CPHA=0 that is the leading phase of each bit; with CPHA=1 it is the trailing phase. A frame therefore has exactly `nbits_i` strobes.
- R7: In wide mode (`wide_mode_i`=1), `sample_alt_i`=1 moves the strobe to the other phase of each bit from the one R6 selects.
- R8: In wide mode, `cs_act_high_i`=1 makes the active level of `cs_o` 1 and its inactive level 0. In narrow mode the active level is 0 regardless of `cs_act_high_i`.
- R9: In narrow mode (`wide_mode_i`=0), only bits 7:0 of `sck_high_i`, `sck_low_i`, `cs_setup_i` and `cs_hold_i` count, and `sample_alt_i` has no effect.
- R10: A start while `busy_o` is 1, or a start with `nbits_i`=0, is ignored. The outputs follow the frame in progress, or stay idle.
- R11: Timing, mode, polarity and edge inputs are captured in the cycle a start is accepted. Changes to them during a frame do not alter that frame.
- R12: A start presented in the cycle where `done_o` is 1 is accepted, so frames may run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request |
| nbits_i | input | BITS_W | Number of bits in the frame |
| wide_mode_i | input | 1 | 1: 16-bit timing and extra options; 0: narrow compatible mode |
| sck_high_i | input | TIME_W | Serial clock high time minus one |
| sck_low_i | input | TIME_W | Serial clock low time minus one |
| cs_setup_i | input | TIME_W | Chip-select setup time minus one |
| cs_hold_i | input | TIME_W | Chip-select hold time minus one |
| cs_idle_i | input | IDLE_W | Chip-select idle gap minus one |
| cpol_i | input | 1 | Serial clock rest level |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing |
| cs_act_high_i | input | 1 | Active-high chip select (wide mode only) |
| sample_alt_i | input | 1 | Sample on the opposite edge (wide mode only) |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| sample_o | output | 1 | Capture strobe, first cycle after a sample edge |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every output is decoded from state registers, so a start accepted at a clock edge shows its first setup cycle on the pins right after that edge. Every later result moves by exactly the programmed count plus one per interval. The bench uses the requirements to build the complete per-cycle sequence of `busy_o`, `done_o`, `cs_o`, `sck_o` and `sample_o` for each accepted start. It pops one entry after each rising edge and compares it at the following falling edge, where the design has settled and before new stimulus is applied. Ignored starts and mid-frame reprogramming are judged the same way: the outputs that follow must match the sequence already queued, or the idle levels.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LEAD  = 3'd2,
    ST_TRAIL = 3'd3,
    ST_HOLD  = 3'd4,
    ST_GAP   = 3'd5
  } tg_state_e;

  // 1 when data is captured in the leading phase of each bit.
  function automatic logic sample_on_lead(input logic cpha, input logic alt_edge,
                                          input logic wide);
    return ~(cpha ^ (alt_edge & wide));
  endfunction

  // Active level of chip select; narrow mode is always active low.
  function automatic logic cs_active_level(input logic act_high, input logic wide);
    return act_high & wide;
  endfunction

endpackage

// File: rtl/spi_tg_cfg.sv
module spi_tg_cfg
  import spi_tg_pkg::*;
#(
  parameter int TIME_W   = 16,
  parameter int NARROW_W = 8,
  parameter int IDLE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [TIME_W-1:0] sck_high_i,
  input  logic [TIME_W-1:0] sck_low_i,
  input  logic [TIME_W-1:0] cs_setup_i,
  input  logic [TIME_W-1:0] cs_hold_i,
  input  logic [IDLE_W-1:0] cs_idle_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              cs_act_high_i,
  input  logic              sample_alt_i,
  output logic [TIME_W-1:0] high_q,
  output logic [TIME_W-1:0] low_q,
  output logic [TIME_W-1:0] setup_q,
  output logic [TIME_W-1:0] hold_q,
  output logic [IDLE_W-1:0] gap_q,
  output logic              pol_q,
  output logic              lead_samp_q,
  output logic              cs_act_q,
  output logic              wide_q
);

  localparam int NFIELD = 4;

  function automatic logic [TIME_W-1:0] fit_field(input logic [TIME_W-1:0] f,
                                                  input logic wide);
    logic [TIME_W-1:0] m;
    m = '0;
    m[NARROW_W-1:0] = f[NARROW_W-1:0];
    return wide ? f : m;
  endfunction

  logic [NFIELD-1:0][TIME_W-1:0] raw;
  logic [NFIELD-1:0][TIME_W-1:0] held;

  assign raw[0] = sck_high_i;
  assign raw[1] = sck_low_i;
  assign raw[2] = cs_setup_i;
  assign raw[3] = cs_hold_i;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    logic [TIME_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load_i) q <= fit_field(raw[g], wide_i);
    end
    assign held[g] = q;
  end

  assign high_q  = held[0];
  assign low_q   = held[1];
  assign setup_q = held[2];
  assign hold_q  = held[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= '0;
      pol_q       <= 1'b0;
      lead_samp_q <= 1'b1;
      cs_act_q    <= 1'b0;
      wide_q      <= 1'b0;
    end else if (load_i) begin
      gap_q       <= cs_idle_i;
      pol_q       <= cpol_i;
      lead_samp_q <= sample_on_lead(cpha_i, sample_alt_i, wide_i);
      cs_act_q    <= cs_active_level(cs_act_high_i, wide_i);
      wide_q      <= wide_i;
    end
  end

endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
  import spi_tg_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int IDLE_W = 8,
  parameter int BITS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BITS_W-1:0] nbits_i,
  input  logic [TIME_W-1:0] high_q,
  input  logic [TIME_W-1:0] low_q,
  input  logic [TIME_W-1:0] setup_q,
  input  logic [TIME_W-1:0] hold_q,
  input  logic [IDLE_W-1:0] gap_q,
  input  logic              pol_q,
  output tg_state_e         state_o,
  output logic              first_o,
  output logic              accept_o,
  output logic              done_o
);

  localparam int CNT_W = (TIME_W > IDLE_W) ? TIME_W : IDLE_W;

  tg_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [BITS_W-1:0] bits_left;
  logic              phase_end;
  tg_state_e         next_state;

  // Phase length follows the pin level: the leading phase sits at ~pol.
  always_comb begin
    unique case (state)
      ST_SETUP: limit = CNT_W'(setup_q);
      ST_LEAD:  limit = pol_q ? CNT_W'(low_q)  : CNT_W'(high_q);
      ST_TRAIL: limit = pol_q ? CNT_W'(high_q) : CNT_W'(low_q);
      ST_HOLD:  limit = CNT_W'(hold_q);
      ST_GAP:   limit = CNT_W'(gap_q);
      default:  limit = '0;
    endcase
  end

  assign phase_end = (state != ST_IDLE) && (cnt == limit);
  assign accept_o  = (state == ST_IDLE) && start_i && (nbits_i != '0);

  always_comb begin
    unique case (state)
      ST_SETUP: next_state = ST_LEAD;
      ST_LEAD:  next_state = ST_TRAIL;
      ST_TRAIL: next_state = (bits_left == BITS_W'(1)) ? ST_HOLD : ST_LEAD;
      ST_HOLD:  next_state = ST_GAP;
      default:  next_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      first_o   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      first_o <= 1'b0;
      done_o  <= 1'b0;
      if (state == ST_IDLE) begin
        if (accept_o) begin
          state     <= ST_SETUP;
          cnt       <= '0;
          bits_left <= nbits_i;
          first_o   <= 1'b1;
        end
      end else if (phase_end) begin
        state   <= next_state;
        cnt     <= '0;
        first_o <= (next_state != ST_IDLE);
        done_o  <= (state == ST_GAP);
        if (state == ST_TRAIL) bits_left <= bits_left - BITS_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign state_o = state;

endmodule

// File: rtl/spi_tg_pins.sv
module spi_tg_pins
  import spi_tg_pkg::*;
(
  input  tg_state_e state_i,
  input  logic      first_i,
  input  logic      pol_q,
  input  logic      lead_samp_q,
  input  logic      cs_act_q,
  output logic      sck_o,
  output logic      cs_o,
  output logic      sample_o,
  output logic      busy_o,
  output logic      in_frame_o
);

  logic in_lead;
  logic in_trail;

  assign in_lead    = (state_i == ST_LEAD);
  assign in_trail   = (state_i == ST_TRAIL);
  assign in_frame_o = (state_i == ST_SETUP) || in_lead || in_trail ||
                      (state_i == ST_HOLD);
  assign busy_o     = (state_i != ST_IDLE);
  assign sck_o      = in_lead ? ~pol_q : pol_q;
  assign cs_o       = in_frame_o ? cs_act_q : ~cs_act_q;
  assign sample_o   = first_i & ((in_lead & lead_samp_q) | (in_trail & ~lead_samp_q));

endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
  import spi_tg_pkg::*;
#(
  parameter int TIME_W   = 16,
  parameter int NARROW_W = 8,
  parameter int IDLE_W   = 8,
  parameter int BITS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BITS_W-1:0] nbits_i,
  input  logic              wide_mode_i,
  input  logic [TIME_W-1:0] sck_high_i,
  input  logic [TIME_W-1:0] sck_low_i,
  input  logic [TIME_W-1:0] cs_setup_i,
  input  logic [TIME_W-1:0] cs_hold_i,
  input  logic [IDLE_W-1:0] cs_idle_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              cs_act_high_i,
  input  logic              sample_alt_i,
  output logic              sck_o,
  output logic              cs_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [TIME_W-1:0] high_q, low_q, setup_q, hold_q;
  logic [IDLE_W-1:0] gap_q;
  logic              pol_q, lead_samp_q, cs_act_q, wide_q;
  logic              accept, first;
  logic              in_frame;
  logic              nbits_zero;
  tg_state_e         state;

  assign nbits_zero = (nbits_i == '0);

  spi_tg_cfg #(
    .TIME_W(TIME_W), .NARROW_W(NARROW_W), .IDLE_W(IDLE_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .wide_i(wide_mode_i),
    .sck_high_i(sck_high_i), .sck_low_i(sck_low_i),
    .cs_setup_i(cs_setup_i), .cs_hold_i(cs_hold_i), .cs_idle_i(cs_idle_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .cs_act_high_i(cs_act_high_i),
    .sample_alt_i(sample_alt_i),
    .high_q(high_q), .low_q(low_q), .setup_q(setup_q), .hold_q(hold_q),
    .gap_q(gap_q), .pol_q(pol_q), .lead_samp_q(lead_samp_q),
    .cs_act_q(cs_act_q), .wide_q(wide_q)
  );

  spi_tg_seq #(
    .TIME_W(TIME_W), .IDLE_W(IDLE_W), .BITS_W(BITS_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbits_i(nbits_i),
    .high_q(high_q), .low_q(low_q), .setup_q(setup_q), .hold_q(hold_q),
    .gap_q(gap_q), .pol_q(pol_q),
    .state_o(state), .first_o(first), .accept_o(accept), .done_o(done_o)
  );

  spi_tg_pins u_pins (
    .state_i(state), .first_i(first), .pol_q(pol_q),
    .lead_samp_q(lead_samp_q), .cs_act_q(cs_act_q),
    .sck_o(sck_o), .cs_o(cs_o), .sample_o(sample_o),
    .busy_o(busy_o), .in_frame_o(in_frame)
  );

endmodule

// File: rtl/spi_tg_checker.sv
module spi_tg_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic nbits_zero,
  input logic busy_o,
  input logic done_o,
  input logic sck_o,
  input logic cs_o,
  input logic sample_o,
  input logic in_frame,
  input logic wide_q,
  input logic cs_act_q
);

  assert_frame_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !nbits_zero && !busy_o) |=> (busy_o && in_frame && cs_o == cs_act_q));

  assert_sck_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(sck_o));

  assert_gap_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !in_frame) |-> (cs_o != cs_act_q));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_sample_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> in_frame);

  assert_narrow_cs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !wide_q) |-> !cs_o);

  assert_zero_bits_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && nbits_zero) |=> !busy_o);

endmodule

bind spi_timing_gen spi_tg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbits_zero(nbits_zero),
  .busy_o(busy_o), .done_o(done_o), .sck_o(sck_o), .cs_o(cs_o),
  .sample_o(sample_o), .in_frame(in_frame), .wide_q(wide_q), .cs_act_q(cs_act_q)
);

// File: tb/tb_spi_timing_gen.sv
module tb_spi_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int TIME_W = 16;
  localparam int IDLE_W = 8;
  localparam int BITS_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [BITS_W-1:0] nbits_i = '0;
  logic wide_mode_i = 1'b1;
  logic [TIME_W-1:0] sck_high_i = '0, sck_low_i = '0, cs_setup_i = '0, cs_hold_i = '0;
  logic [IDLE_W-1:0] cs_idle_i = '0;
  logic cpol_i = 1'b0, cpha_i = 1'b0, cs_act_high_i = 1'b0, sample_alt_i = 1'b0;
  logic sck_o, cs_o, sample_o, busy_o, done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbits_i(nbits_i),
    .wide_mode_i(wide_mode_i), .sck_high_i(sck_high_i), .sck_low_i(sck_low_i),
    .cs_setup_i(cs_setup_i), .cs_hold_i(cs_hold_i), .cs_idle_i(cs_idle_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .cs_act_high_i(cs_act_high_i),
    .sample_alt_i(sample_alt_i), .sck_o(sck_o), .cs_o(cs_o),
    .sample_o(sample_o), .busy_o(busy_o), .done_o(done_o)
  );

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string cur_req = "R1";
  logic [4:0] exp_q[$];   // {busy, done, cs, sck, sample}
  logic  last_pol = 1'b0;
  logic  last_act = 1'b0;

  function automatic int eff(input logic [TIME_W-1:0] f, input logic w);
    return w ? int'(f) : int'(f[7:0]);
  endfunction

  // Builds the expected per-cycle outputs of one frame from the requirements.
  task automatic build_frame();
    logic w, pol, act, lead;
    int s, hi, lo, h, g, dl, dt;
    w    = wide_mode_i;
    pol  = cpol_i;
    act  = w & cs_act_high_i;
    lead = (cpha_i == 1'b0) ^ (w & sample_alt_i);
    s = eff(cs_setup_i, w); h = eff(cs_hold_i, w);
    hi = eff(sck_high_i, w); lo = eff(sck_low_i, w); g = int'(cs_idle_i);
    dl = pol ? lo : hi;
    dt = pol ? hi : lo;
    for (int i = 0; i <= s; i++) exp_q.push_back({1'b1, 1'b0, act, pol, 1'b0});
    for (int b = 0; b < int'(nbits_i); b++) begin
      for (int j = 0; j <= dl; j++)
        exp_q.push_back({1'b1, 1'b0, act, ~pol, (j == 0) && lead});
      for (int j = 0; j <= dt; j++)
        exp_q.push_back({1'b1, 1'b0, act, pol, (j == 0) && !lead});
    end
    for (int i = 0; i <= h; i++) exp_q.push_back({1'b1, 1'b0, act, pol, 1'b0});
    for (int i = 0; i <= g; i++) exp_q.push_back({1'b1, 1'b0, ~act, pol, 1'b0});
    exp_q.push_back({1'b0, 1'b1, ~act, pol, 1'b0});
    last_pol = pol;
    last_act = act;
  endtask

  task automatic compare_cycle();
    logic [4:0] e, a;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : {1'b0, 1'b0, ~last_act, last_pol, 1'b0};
    a = {busy_o, done_o, cs_o, sck_o, sample_o};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s at %0t: {busy,done,cs,sck,sample} actual %b expected %b",
               cur_req, $time, a, e);
    end
  endtask

  task automatic tick();
    if (start_i && nbits_i != '0 && exp_q.size() == 0) build_frame();
    @(posedge clk);
    @(negedge clk);
    compare_cycle();
  endtask

  task automatic run_frame(input int n);
    nbits_i = BITS_W'(n);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    while (exp_q.size() > 0) tick();
  endtask

  task automatic set_timing(input int hi, input int lo, input int su, input int ho,
                            input int gp);
    sck_high_i = TIME_W'(hi); sck_low_i = TIME_W'(lo);
    cs_setup_i = TIME_W'(su); cs_hold_i = TIME_W'(ho); cs_idle_i = IDLE_W'(gp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset levels
    repeat (3) @(negedge clk);
    checks++;
    if ({busy_o, done_o, cs_o, sck_o, sample_o} !== 5'b00100) begin
      fails++;
      $display("FAIL R1 in reset: actual %b expected 00100",
               {busy_o, done_o, cs_o, sck_o, sample_o});
    end
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (2) tick();

    // R2 R3 R4 R5 R6: mode 0, distinct high/low/setup/hold/idle
    cur_req = "R2 R3 R4 R5 R6 basic";
    set_timing(2, 1, 3, 2, 4);
    run_frame(3);
    repeat (2) tick();

    // R3 R6: CPOL=1 CPHA=1, asymmetric halves
    cur_req = "R3 R6 cpol1 cpha1";
    cpol_i = 1'b1; cpha_i = 1'b1;
    set_timing(0, 3, 1, 0, 1);
    run_frame(2);
    repeat (2) tick();

    // R7: alternate sample edge in wide mode
    cur_req = "R7 alt edge";
    cpol_i = 1'b0; cpha_i = 1'b0; sample_alt_i = 1'b1;
    set_timing(1, 2, 0, 1, 0);
    run_frame(4);
    cpha_i = 1'b1;
    run_frame(2);
    sample_alt_i = 1'b0;
    repeat (2) tick();

    // R8: active-high chip select in wide mode
    cur_req = "R8 cs high";
    cs_act_high_i = 1'b1;
    set_timing(1, 1, 2, 2, 3);
    run_frame(2);
    repeat (3) tick();

    // R8 R9: narrow mode masks fields, ignores alt edge and cs polarity
    cur_req = "R8 R9 narrow";
    wide_mode_i = 1'b0; sample_alt_i = 1'b1; cpha_i = 1'b0;
    set_timing(16'h0102, 16'h0301, 16'h0200, 16'h0101, 2);
    run_frame(3);
    repeat (2) tick();
    wide_mode_i = 1'b1; sample_alt_i = 1'b0; cs_act_high_i = 1'b0;

    // R10: start while busy and start with zero bits are ignored
    cur_req = "R10 ignored starts";
    set_timing(1, 1, 1, 1, 1);
    nbits_i = 8'd2; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    repeat (3) tick();
    nbits_i = 8'd5; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    while (exp_q.size() > 0) tick();
    nbits_i = '0; start_i = 1'b1;
    repeat (4) tick();
    start_i = 1'b0;
    repeat (2) tick();

    // R11: reprogramming mid-frame has no effect on the frame
    cur_req = "R11 snapshot";
    set_timing(2, 2, 1, 1, 1);
    nbits_i = 8'd3; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    repeat (2) tick();
    set_timing(0, 5, 7, 0, 0);
    cpol_i = 1'b1; cpha_i = 1'b1; cs_act_high_i = 1'b1; wide_mode_i = 1'b0;
    while (exp_q.size() > 0) tick();
    cpol_i = 1'b0; cpha_i = 1'b0; cs_act_high_i = 1'b0; wide_mode_i = 1'b1;
    repeat (2) tick();

    // R12: start in the done cycle is accepted (frames back to back)
    cur_req = "R12 back to back";
    set_timing(0, 0, 0, 0, 0);
    run_frame(1);
    run_frame(2);
    run_frame(1);
    repeat (3) tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule